// File: doc/BRIEF.md
# Edge-Delayed Output Filter

This block drives one general-purpose output that tracks a logic input, with an optional delay applied separately to rising and falling changes. The delay is a count of ticks from an external prescaler enable, so the same logic serves microsecond or millisecond timebases. A count of zero, or a cleared enable for an edge, makes that edge pass straight through after synchronisation.

A mode pin selects between two behaviours. With the pin low, the block is a glitch filter: a change that reverts before its delay runs out never reaches the output. With the pin high, the block is a pulse stretcher: once a change is seen, its delay runs to completion regardless of the input, the output then takes the new level, and every output pulse lasts at least one delay period. When a delay expires in this mode and the input already sits at the opposite level, the delay for that opposite edge starts in the same cycle.

All pins are plain control and status levels; there is no data stream, so no valid/ready handshake and no back-pressure. The asynchronous input passes through a two-flop synchroniser before any decision is made.

Top module: `edge_delay_filter`

## Requirements
- R1: While reset is asserted and after its release with the input low, the output is 0 and no delay is running.
- R2: The input is resynchronised by two flops; an undelayed change on `din` present before rising edge 1 appears on `dout` after rising edge 3.
- R3: With `dly_rise_en`=1 and `dly_ticks`=N>0, a held 0-to-1 change appears N ticks after the controller sees it; with `tick_en` high every cycle, `dout` rises after edge 3+N.
- R4: With `dly_fall_en`=1 and `dly_ticks`=N>0, a held 1-to-0 change appears on `dout` after edge 3+N with `tick_en` high every cycle.
- R5: An edge whose delay enable is 0 follows with the R2 latency, whatever the other edge's setting.
- R6: `dly_ticks`=0 behaves as no delay on both edges.
- R7: With `hold_mode`=0, a change that reverts before its delay expires leaves `dout` unchanged.
- R8: With `hold_mode`=1, a started delay always completes and `dout` takes the new level on expiry even if the input has reverted.
- R9: With `hold_mode`=1, input activity during a running delay is ignored; if at expiry the input differs from the new output, the opposite edge's delay starts in that cycle, so each output pulse lasts at least N ticks.
- R10: The delay counter advances only on cycles where `tick_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler pulse; one delay tick per high cycle |
| din | input | 1 | Asynchronous logic input |
| dly_rise_en | input | 1 | Apply delay to 0-to-1 changes |
| dly_fall_en | input | 1 | Apply delay to 1-to-0 changes |
| dly_ticks | input | 16 | Delay length in ticks; 0 means no delay |
| hold_mode | input | 1 | 0: glitch filter, 1: ignore input while delaying |
| dout | output | 1 | Filtered output |

## Verification
The hardest situation to reach is the in-cycle restart in ignore mode, where a delay expires while the input already sits at the opposite level. The bench reaches it with an input pulse of three cycles against a five-tick delay, then checks the exact cycle the output rises, that it stays high through a second short input pulse during the follow-on delay, and the exact cycle it falls. The tick-gating case is reached by holding the prescaler pulse low across a long input change and releasing it later.

// File: rtl/edf_pkg.sv
package edf_pkg;
  typedef enum logic {
    EDF_IDLE = 1'b0,
    EDF_RUN  = 1'b1
  } edf_phase_t;
endpackage

// File: rtl/edf_sync.sv
module edf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edf_timer.sv
module edf_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stop,
  output logic             busy,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= load_val;
      busy <= 1'b1;
    end else if (stop) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      cnt <= cnt - ONE;
    end
  end

  assign expire = busy && tick && (cnt == ONE);
endmodule

// File: rtl/edf_ctrl.sv
module edf_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic [CNT_W-1:0] ticks,
  input  logic             hold_mode,
  input  logic             busy,
  input  logic             expire,
  output logic             load,
  output logic             stop,
  output logic             dout,
  output logic             tgt
);
  import edf_pkg::*;

  edf_phase_t phase;
  logic       dly_on;
  logic       dout_nx, tgt_nx;

  assign phase  = busy ? EDF_RUN : EDF_IDLE;
  // delay applies to a change towards level s
  assign dly_on = (s ? rise_en : fall_en) && (ticks != '0);

  always_comb begin
    load    = 1'b0;
    stop    = 1'b0;
    dout_nx = dout;
    tgt_nx  = tgt;
    unique case (phase)
      EDF_IDLE: begin
        if (s != dout) begin
          if (dly_on) begin
            load   = 1'b1;
            tgt_nx = s;
          end else begin
            dout_nx = s;
          end
        end
      end
      EDF_RUN: begin
        if (!hold_mode && (s != tgt)) begin
          stop = 1'b1;
        end else if (expire) begin
          dout_nx = tgt;
          if (hold_mode && (s != tgt) && dly_on) begin
            load   = 1'b1;
            tgt_nx = s;
          end else begin
            stop = 1'b1;
          end
        end
      end
      default: stop = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      tgt  <= 1'b0;
    end else begin
      dout <= dout_nx;
      tgt  <= tgt_nx;
    end
  end
endmodule

// File: rtl/edge_delay_filter.sv
module edge_delay_filter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             din,
  input  logic             dly_rise_en,
  input  logic             dly_fall_en,
  input  logic [CNT_W-1:0] dly_ticks,
  input  logic             hold_mode,
  output logic             dout
);
  logic             s_sync;
  logic             busy, expire, load, stop, tgt;
  logic [CNT_W-1:0] cnt;

  edf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(s_sync)
  );

  edf_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(load),
    .load_val(dly_ticks), .stop(stop), .busy(busy),
    .expire(expire), .cnt(cnt)
  );

  edf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .s(s_sync), .rise_en(dly_rise_en),
    .fall_en(dly_fall_en), .ticks(dly_ticks), .hold_mode(hold_mode),
    .busy(busy), .expire(expire), .load(load), .stop(stop),
    .dout(dout), .tgt(tgt)
  );
endmodule

// File: rtl/edf_checker.sv
module edf_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             s,
  input logic             dout,
  input logic             busy,
  input logic             expire,
  input logic             tgt,
  input logic             hold_mode,
  input logic             rise_en,
  input logic             fall_en,
  input logic [CNT_W-1:0] ticks,
  input logic [CNT_W-1:0] cnt
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !dout));

  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !expire) |=> $stable(dout));

  assert_follow_undelayed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (s != dout) && !(s ? rise_en : fall_en)) |=> (dout == $past(s)));

  assert_zero_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (s != dout) && (ticks == '0)) |=> (dout == $past(s) && !busy));

  assert_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (hold_mode || s == tgt)) |=> (dout == $past(tgt)));

  assert_ignore_keeps_timer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold_mode && !expire) |=> busy);

  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == $past(ticks)));

  assert_tick_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_en) |=> $stable(cnt));
endmodule

bind edge_delay_filter edf_checker #(.CNT_W(CNT_W)) u_edf_checker (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .s(s_sync), .dout(dout),
  .busy(busy), .expire(expire), .tgt(tgt), .hold_mode(hold_mode),
  .rise_en(dly_rise_en), .fall_en(dly_fall_en), .ticks(dly_ticks), .cnt(cnt)
);

// File: tb/test_edge_delay_filter.sv
module test_edge_delay_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        din;
  logic        dly_rise_en;
  logic        dly_fall_en;
  logic [15:0] dly_ticks;
  logic        hold_mode;
  logic        dout;

  int checks = 0;
  int errors = 0;

  edge_delay_filter i_edge_delay_filter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .din(din),
    .dly_rise_en(dly_rise_en), .dly_fall_en(dly_fall_en),
    .dly_ticks(dly_ticks), .hold_mode(hold_mode), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // wait n rising edges, then settle at the following falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input logic re, input logic fe, input int n, input logic hm);
    @(negedge clk);
    rst_n = 1'b0; din = 1'b0; tick_en = 1'b1;
    dly_rise_en = re; dly_fall_en = fe; dly_ticks = 16'(n); hold_mode = hm;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    setup(1'b1, 1'b1, 4, 1'b0);
    rst_n = 1'b0; din = 1'b1;
    step(5);
    check("R1 dout low in reset", dout, 1'b0);
    din = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    check("R1 dout low after reset", dout, 1'b0);
  endtask

  task automatic t_nodelay();
    setup(1'b0, 1'b0, 5, 1'b0);
    din = 1'b1;
    step(2); check("R2 rise not before edge 3", dout, 1'b0);
    step(1); check("R2 rise after edge 3", dout, 1'b1);
    din = 1'b0;
    step(2); check("R5 fall not before edge 3", dout, 1'b1);
    step(1); check("R5 fall after edge 3", dout, 1'b0);
  endtask

  task automatic t_rise_delay();
    setup(1'b1, 1'b0, 4, 1'b0);
    din = 1'b1;
    step(6); check("R3 rise held until edge 7", dout, 1'b0);
    step(1); check("R3 rise after edge 7", dout, 1'b1);
    din = 1'b0;
    step(2); check("R5 undelayed fall early", dout, 1'b1);
    step(1); check("R5 undelayed fall at edge 3", dout, 1'b0);
  endtask

  task automatic t_fall_delay();
    setup(1'b0, 1'b1, 3, 1'b0);
    din = 1'b1;
    step(3); check("R5 undelayed rise at edge 3", dout, 1'b1);
    din = 1'b0;
    step(5); check("R4 fall held until edge 6", dout, 1'b1);
    step(1); check("R4 fall after edge 6", dout, 1'b0);
  endtask

  task automatic t_zero_ticks();
    setup(1'b1, 1'b1, 0, 1'b0);
    din = 1'b1;
    step(2); check("R6 zero ticks early", dout, 1'b0);
    step(1); check("R6 zero ticks rise at edge 3", dout, 1'b1);
    din = 1'b0;
    step(3); check("R6 zero ticks fall at edge 3", dout, 1'b0);
  endtask

  task automatic t_glitch();
    logic seen;
    setup(1'b1, 1'b1, 5, 1'b0);
    din = 1'b1;
    step(3);
    din = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (dout) seen = 1'b1;
    end
    check("R7 short pulse dropped", seen, 1'b0);
    din = 1'b1;
    step(8); check("R7 held change passes", dout, 1'b1);
  endtask

  task automatic t_ignore();
    logic dropped;
    setup(1'b1, 1'b1, 5, 1'b1);
    din = 1'b1;
    step(3);
    din = 1'b0;
    step(4); check("R8 not yet at edge 7", dout, 1'b0);
    step(1); check("R8 committed at edge 8", dout, 1'b1);
    din = 1'b1;
    step(1);
    din = 1'b0;
    step(3); check("R9 still high at edge 12", dout, 1'b1);
    step(1); check("R9 restarted fall at edge 13", dout, 1'b0);
    dropped = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (dout) dropped = 1'b0;
    end
    check("R9 activity during delay ignored", dropped, 1'b1);
  endtask

  task automatic t_tick_gate();
    setup(1'b1, 1'b1, 3, 1'b0);
    tick_en = 1'b0;
    din = 1'b1;
    step(30); check("R10 no ticks no change", dout, 1'b0);
    tick_en = 1'b1;
    step(2); check("R10 two ticks not enough", dout, 1'b0);
    step(1); check("R10 third tick commits", dout, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; din = 1'b0; tick_en = 1'b1;
    dly_rise_en = 1'b0; dly_fall_en = 1'b0; dly_ticks = '0; hold_mode = 1'b0;
    t_reset();
    t_nodelay();
    t_rise_delay();
    t_fall_delay();
    t_zero_ticks();
    t_glitch();
    t_ignore();
    t_tick_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule